// File: doc/BRIEF.md
# Transceiver Status Response Encoder

This block produces the status byte that a line transceiver returns on its control port each time a command is issued. Line events are captured in sticky pending flags: activation complete, deactivation, loss of frame alignment, a lost D-channel collision, receive multiframe error, transmit and receive jitter-buffer slips, the two multiframe buffer service requests and the transmit multiframe clock. Each command response reports the most urgent pending event and retires it. An interrupt line stays high while anything remains pending.

When nothing is pending, a command receives an idle code. That code is either a plain no-change byte or, after state reporting has been switched on, a state-bearing byte that carries the current activation state. Two events are detected inside the block. A lost collision is found by comparing the echo bit with the last transmitted D bit during a packet. The multiframe clock event is derived from multiframe boundary pulses, either on every boundary or once per group of boundaries.

Top module: `tsr_top`

## Requirements
- R1: After reset, `respVld` and `irq` are low, and the first command returns the plain idle code 0x00.
- R2: Each command (`cmdValid` high at a clock edge) produces `respVld` high for one cycle on the next cycle, with `respCode` holding the pending event of highest priority. That event is then cleared. Priority from highest to lowest, with codes: activation complete 0x01, deactivated 0x02, frame alignment lost 0x03, lost collision 0x04, receive multiframe error 0x05, slips 0x09/0x0A/0x0B, buffer-1 service 0x06, buffer-2 service 0x07, multiframe clock 0x08.
- R3: A pending transmit slip alone reports 0x09. A receive slip alone reports 0x0A. Transmit and receive slips pending together, whether they arrived in the same cycle or in different cycles, report 0x0B once and clear both.
- R4: `irq` is high in the cycle after an event pulse and stays high until the response that retires the last pending event.
- R5: With nothing pending, a response returns the idle code and `irq` stays low.
- R6: After `cmdStateEn`, the idle code is 0x10 OR'd with `actState`. `cmdStateDis` restores the plain 0x00.
- R7: After `cmdMf1Off`, buffer-1 service pulses are ignored. After `cmdMf2Off`, buffer-2 service pulses are ignored.
- R8: After `cmdMfClkEach`, every `mfBoundary` pulse raises the multiframe clock event. After `cmdMfClkGroup`, only every MF_GROUP-th boundary counted from that command raises it.
- R9: A lost collision is raised on `echoStrobe` when `pktActive` is high and `echoBit` differs from the D bit last latched by `dTxStrobe`. Nothing is raised when the bits match or when no packet is active.
- R10: An event that arrives at the same edge as a command is not part of that response. It is kept and reported by the next command.
- R11: Until a multiframe clock enable command has been given, boundary pulses raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command was received; a response is due |
| cmdStateEn | input | 1 | Switch idle code to the state-bearing form |
| cmdStateDis | input | 1 | Switch idle code back to plain 0x00 |
| cmdMf1Off | input | 1 | Ignore buffer-1 service requests |
| cmdMf2Off | input | 1 | Ignore buffer-2 service requests |
| cmdMfClkEach | input | 1 | Multiframe clock on every boundary |
| cmdMfClkGroup | input | 1 | Multiframe clock every MF_GROUP boundaries; restarts the count |
| actState | input | STATE_W | Current activation state |
| evActDone | input | 1 | Activation complete pulse |
| evDeact | input | 1 | Deactivated pulse |
| evFrameLoss | input | 1 | Frame alignment lost pulse |
| evRxMfErr | input | 1 | Receive multiframe error pulse |
| evTxSlip | input | 1 | Transmit buffer slip pulse |
| evRxSlip | input | 1 | Receive buffer slip pulse |
| evMf1Req | input | 1 | Buffer-1 service request pulse |
| evMf2Req | input | 1 | Buffer-2 service request pulse |
| mfBoundary | input | 1 | Transmit multiframe boundary pulse |
| pktActive | input | 1 | A D-channel packet is being sent |
| dTxStrobe | input | 1 | Latch `dTxBit` as the last transmitted D bit |
| dTxBit | input | 1 | Transmitted D bit |
| echoStrobe | input | 1 | Compare `echoBit` now |
| echoBit | input | 1 | Received echo bit |
| respVld | output | 1 | Response byte valid |
| respCode | output | 8 | Response byte |
| irq | output | 1 | Reportable events pending |

## Verification
The bench builds the block with MF_GROUP=4 and STATE_W=3. A group of four boundaries lets the every-Nth clock mode be shown firing on the fourth boundary and staying silent on the first three, within a few cycles. A three-bit state places the state-bearing idle code at 0x15 for state 5, which tests that the state field is inserted correctly. One burst that raises every event at once walks the complete priority order and checks that the interrupt is released after the final read.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // Flag indices, lowest index = highest priority
  localparam int FL_ACT    = 0;
  localparam int FL_DEACT  = 1;
  localparam int FL_FRAME  = 2;
  localparam int FL_COLL   = 3;
  localparam int FL_RXERR  = 4;
  localparam int FL_TXSLIP = 5;
  localparam int FL_RXSLIP = 6;
  localparam int FL_MF1    = 7;
  localparam int FL_MF2    = 8;
  localparam int FL_MFCLK  = 9;
  localparam int NUM_FLAGS = 10;
  localparam int FLAG_IW   = $clog2(NUM_FLAGS);

  localparam logic [7:0] CODE_IDLE   = 8'h00;
  localparam logic [7:0] CODE_ACT    = 8'h01;
  localparam logic [7:0] CODE_DEACT  = 8'h02;
  localparam logic [7:0] CODE_FRAME  = 8'h03;
  localparam logic [7:0] CODE_COLL   = 8'h04;
  localparam logic [7:0] CODE_RXERR  = 8'h05;
  localparam logic [7:0] CODE_MF1    = 8'h06;
  localparam logic [7:0] CODE_MF2    = 8'h07;
  localparam logic [7:0] CODE_MFCLK  = 8'h08;
  localparam logic [7:0] CODE_TXSLIP = 8'h09;
  localparam logic [7:0] CODE_RXSLIP = 8'h0A;
  localparam logic [7:0] CODE_BOTH   = 8'h0B;
  localparam logic [7:0] CODE_STBASE = 8'h10;

  typedef enum logic [1:0] {MFC_OFF, MFC_EACH, MFC_GROUP} mfcMode_t;

  // Strobes and held modes from control to datapath
  typedef struct packed {
    logic readNow;
    logic stateRpt;
    logic mf1Off;
    logic mf2Off;
    logic mfEach;
    logic mfGroup;
    logic mfRestart;
  } ctlStrb_t;
endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     cmdStateEn,
  input  logic     cmdStateDis,
  input  logic     cmdMf1Off,
  input  logic     cmdMf2Off,
  input  logic     cmdMfClkEach,
  input  logic     cmdMfClkGroup,
  output ctlStrb_t ctl
);
  logic     stateRpt;
  logic     mf1Off;
  logic     mf2Off;
  mfcMode_t mfMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateRpt <= 1'b0;
      mf1Off   <= 1'b0;
      mf2Off   <= 1'b0;
      mfMode   <= MFC_OFF;
    end else begin
      if (cmdStateDis)      stateRpt <= 1'b0;
      else if (cmdStateEn)  stateRpt <= 1'b1;
      if (cmdMf1Off)        mf1Off   <= 1'b1;
      if (cmdMf2Off)        mf2Off   <= 1'b1;
      if (cmdMfClkGroup)    mfMode   <= MFC_GROUP;
      else if (cmdMfClkEach) mfMode  <= MFC_EACH;
    end
  end

  always_comb begin
    ctl.readNow   = cmdValid;
    ctl.stateRpt  = stateRpt;
    ctl.mf1Off    = mf1Off;
    ctl.mf2Off    = mf2Off;
    ctl.mfEach    = (mfMode == MFC_EACH);
    ctl.mfGroup   = (mfMode == MFC_GROUP);
    ctl.mfRestart = cmdMfClkGroup;
  end
endmodule

// File: rtl/tsr_evtsrc.sv
module tsr_evtsrc
  import tsr_pkg::*;
#(
  parameter int MF_GROUP = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctlStrb_t ctl,
  input  logic     mfBoundary,
  input  logic     pktActive,
  input  logic     dTxStrobe,
  input  logic     dTxBit,
  input  logic     echoStrobe,
  input  logic     echoBit,
  output logic     evCollision,
  output logic     evMfTick
);
  localparam int CW = (MF_GROUP > 2) ? $clog2(MF_GROUP) : 1;
  localparam logic [CW-1:0] LAST = CW'(MF_GROUP - 1);

  logic          lastTxD;
  logic [CW-1:0] bndCnt;
  logic          groupEnd;

  always_ff @(posedge clk) begin
    if (!rstN)          lastTxD <= 1'b0;
    else if (dTxStrobe) lastTxD <= dTxBit;
  end

  assign evCollision = echoStrobe & pktActive & (echoBit != lastTxD);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.mfRestart) bndCnt <= '0;
    else if (mfBoundary)        bndCnt <= groupEnd ? '0 : bndCnt + 1'b1;
  end

  assign groupEnd = (bndCnt == LAST);
  assign evMfTick = mfBoundary & ~ctl.mfRestart &
                    (ctl.mfEach | (ctl.mfGroup & groupEnd));
endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int STATE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrb_t             ctl,
  input  logic [STATE_W-1:0]   actState,
  input  logic [NUM_FLAGS-1:0] evRaw,
  output logic                 respVld,
  output logic [7:0]           respCode,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [FLAG_IW-1:0]   selIdx;
  logic                 selFound;
  logic [7:0]           selCode;
  logic [7:0]           idleCode;

  always_comb begin
    setVec         = evRaw;
    setVec[FL_MF1] = evRaw[FL_MF1] & ~ctl.mf1Off;
    setVec[FL_MF2] = evRaw[FL_MF2] & ~ctl.mf2Off;
  end

  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
      if (flags[i]) begin
        selFound = 1'b1;
        selIdx   = FLAG_IW'(i);
      end
    end
  end

  always_comb begin
    clrVec = '0;
    if (ctl.readNow && selFound) begin
      clrVec[selIdx] = 1'b1;
      if (selIdx == FLAG_IW'(FL_TXSLIP) || selIdx == FLAG_IW'(FL_RXSLIP)) begin
        clrVec[FL_TXSLIP] = 1'b1;
        clrVec[FL_RXSLIP] = 1'b1;
      end
    end
  end

  always_comb begin
    idleCode = ctl.stateRpt ? (CODE_STBASE | 8'(actState)) : CODE_IDLE;
    unique case (int'(selIdx))
      FL_ACT:    selCode = CODE_ACT;
      FL_DEACT:  selCode = CODE_DEACT;
      FL_FRAME:  selCode = CODE_FRAME;
      FL_COLL:   selCode = CODE_COLL;
      FL_RXERR:  selCode = CODE_RXERR;
      FL_TXSLIP: selCode = flags[FL_RXSLIP] ? CODE_BOTH : CODE_TXSLIP;
      FL_RXSLIP: selCode = CODE_RXSLIP;
      FL_MF1:    selCode = CODE_MF1;
      FL_MF2:    selCode = CODE_MF2;
      FL_MFCLK:  selCode = CODE_MFCLK;
      default:   selCode = CODE_IDLE;
    endcase
    if (!selFound) selCode = idleCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      respVld  <= 1'b0;
      respCode <= CODE_IDLE;
    end else begin
      flags   <= (flags & ~clrVec) | setVec;
      respVld <= ctl.readNow;
      if (ctl.readNow) respCode <= selCode;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/tsr_top.sv
module tsr_top
  import tsr_pkg::*;
#(
  parameter int STATE_W  = 3,
  parameter int MF_GROUP = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic               cmdStateEn,
  input  logic               cmdStateDis,
  input  logic               cmdMf1Off,
  input  logic               cmdMf2Off,
  input  logic               cmdMfClkEach,
  input  logic               cmdMfClkGroup,
  input  logic [STATE_W-1:0] actState,
  input  logic               evActDone,
  input  logic               evDeact,
  input  logic               evFrameLoss,
  input  logic               evRxMfErr,
  input  logic               evTxSlip,
  input  logic               evRxSlip,
  input  logic               evMf1Req,
  input  logic               evMf2Req,
  input  logic               mfBoundary,
  input  logic               pktActive,
  input  logic               dTxStrobe,
  input  logic               dTxBit,
  input  logic               echoStrobe,
  input  logic               echoBit,
  output logic               respVld,
  output logic [7:0]         respCode,
  output logic               irq
);
  ctlStrb_t             ctl;
  logic                 evCollision;
  logic                 evMfTick;
  logic [NUM_FLAGS-1:0] evRaw;

  tsr_ctrl ctrl_i (
    .clk, .rstN, .cmdValid, .cmdStateEn, .cmdStateDis,
    .cmdMf1Off, .cmdMf2Off, .cmdMfClkEach, .cmdMfClkGroup, .ctl
  );

  tsr_evtsrc #(.MF_GROUP(MF_GROUP)) evt_i (
    .clk, .rstN, .ctl, .mfBoundary, .pktActive, .dTxStrobe, .dTxBit,
    .echoStrobe, .echoBit, .evCollision, .evMfTick
  );

  always_comb begin
    evRaw            = '0;
    evRaw[FL_ACT]    = evActDone;
    evRaw[FL_DEACT]  = evDeact;
    evRaw[FL_FRAME]  = evFrameLoss;
    evRaw[FL_COLL]   = evCollision;
    evRaw[FL_RXERR]  = evRxMfErr;
    evRaw[FL_TXSLIP] = evTxSlip;
    evRaw[FL_RXSLIP] = evRxSlip;
    evRaw[FL_MF1]    = evMf1Req;
    evRaw[FL_MF2]    = evMf2Req;
    evRaw[FL_MFCLK]  = evMfTick;
  end

  tsr_datapath #(.STATE_W(STATE_W)) dp_i (
    .clk, .rstN, .ctl, .actState, .evRaw, .respVld, .respCode, .irq
  );
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       respVld,
  input logic [7:0] respCode,
  input logic       irq
);
  // R2
  resp_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    respVld |-> $past(cmdValid));

  // R5
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !irq) |=> (respVld && (respCode == 8'h00 || respCode[7:4] == 4'h1)));

  // R4
  pending_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && irq) |=> (respVld && respCode != 8'h00 && respCode[7:4] == 4'h0));

  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(cmdValid));

  // R3
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    respVld |-> (respCode <= 8'h0B || respCode[7:4] == 4'h1));
endmodule

bind tsr_top tsr_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
  .respVld(respVld), .respCode(respCode), .irq(irq)
);

// File: tb/tsr_top_tb_top.sv
module tsr_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdStateEn = 0, cmdStateDis = 0, cmdMf1Off = 0, cmdMf2Off = 0;
  logic cmdMfClkEach = 0, cmdMfClkGroup = 0;
  logic [2:0] actState = 3'd0;
  logic evActDone = 0, evDeact = 0, evFrameLoss = 0, evRxMfErr = 0;
  logic evTxSlip = 0, evRxSlip = 0, evMf1Req = 0, evMf2Req = 0;
  logic mfBoundary = 0, pktActive = 0, dTxStrobe = 0, dTxBit = 0, echoStrobe = 0, echoBit = 0;
  logic respVld, irq;
  logic [7:0] respCode;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tsr_top #(.STATE_W(3), .MF_GROUP(4)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic readResp(input string req, input logic [7:0] exp);
    @(negedge clk);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk({req, " valid"}, {7'd0, respVld}, 8'd1);
    chk(req, respCode, exp);
  endtask

  task automatic testReset();
    chk("R1 respVld after reset", {7'd0, respVld}, 8'd0);
    chk("R1 irq after reset", {7'd0, irq}, 8'd0);
    readResp("R1 first response", 8'h00);
  endtask

  task automatic testNoClockBeforeEnable();
    step(); mfBoundary = 1; step(); mfBoundary = 0;
    chk("R11 irq after boundary", {7'd0, irq}, 8'd0);
    readResp("R11 no clock event", 8'h00);
  endtask

  task automatic testPriority();
    step(); cmdMfClkEach = 1; step(); cmdMfClkEach = 0;
    evActDone = 1; evDeact = 1; evFrameLoss = 1; evRxMfErr = 1;
    evTxSlip = 1; evRxSlip = 1; evMf1Req = 1; evMf2Req = 1; mfBoundary = 1;
    pktActive = 1; echoStrobe = 1; echoBit = 1;
    step();
    evActDone = 0; evDeact = 0; evFrameLoss = 0; evRxMfErr = 0;
    evTxSlip = 0; evRxSlip = 0; evMf1Req = 0; evMf2Req = 0; mfBoundary = 0;
    pktActive = 0; echoStrobe = 0; echoBit = 0;
    chk("R4 irq raised", {7'd0, irq}, 8'd1);
    readResp("R2 act first", 8'h01);
    readResp("R2 deact", 8'h02);
    readResp("R2 frame", 8'h03);
    readResp("R2 collision", 8'h04);
    readResp("R2 rx mf error", 8'h05);
    readResp("R2 both slips", 8'h0B);
    readResp("R2 buf1", 8'h06);
    chk("R4 irq still high", {7'd0, irq}, 8'd1);
    readResp("R2 buf2", 8'h07);
    readResp("R2 mf clock", 8'h08);
    chk("R4 irq released", {7'd0, irq}, 8'd0);
    readResp("R5 idle after drain", 8'h00);
    chk("R5 irq idle", {7'd0, irq}, 8'd0);
  endtask

  task automatic testSlips();
    step(); evTxSlip = 1; step(); evTxSlip = 0;
    readResp("R3 tx slip", 8'h09);
    step(); evRxSlip = 1; step(); evRxSlip = 0;
    readResp("R3 rx slip", 8'h0A);
    step(); evTxSlip = 1; step(); evTxSlip = 0;
    step(); evRxSlip = 1; step(); evRxSlip = 0;
    readResp("R3 merged slips", 8'h0B);
    readResp("R3 single report", 8'h00);
  endtask

  task automatic testStateMode();
    actState = 3'd5;
    step(); cmdStateEn = 1; step(); cmdStateEn = 0;
    readResp("R6 state idle", 8'h15);
    chk("R6 no irq", {7'd0, irq}, 8'd0);
    step(); evActDone = 1; step(); evActDone = 0;
    readResp("R6 event over state", 8'h01);
    readResp("R6 state idle again", 8'h15);
    step(); cmdStateDis = 1; step(); cmdStateDis = 0;
    readResp("R6 plain restored", 8'h00);
  endtask

  task automatic testMasks();
    step(); cmdMf1Off = 1; step(); cmdMf1Off = 0;
    evMf1Req = 1; step(); evMf1Req = 0;
    chk("R7 buf1 masked irq", {7'd0, irq}, 8'd0);
    readResp("R7 buf1 masked", 8'h00);
    evMf2Req = 1; step(); evMf2Req = 0;
    readResp("R7 buf2 still live", 8'h07);
    step(); cmdMf2Off = 1; step(); cmdMf2Off = 0;
    evMf2Req = 1; step(); evMf2Req = 0;
    readResp("R7 buf2 masked", 8'h00);
  endtask

  task automatic testMfClock();
    step(); mfBoundary = 1; step(); mfBoundary = 0;
    readResp("R8 each boundary", 8'h08);
    step(); cmdMfClkGroup = 1; step(); cmdMfClkGroup = 0;
    for (int k = 1; k <= 3; k++) begin
      mfBoundary = 1; step(); mfBoundary = 0; step();
      chk("R8 group quiet", {7'd0, irq}, 8'd0);
    end
    mfBoundary = 1; step(); mfBoundary = 0;
    readResp("R8 group fourth", 8'h08);
  endtask

  task automatic testCollision();
    step(); dTxStrobe = 1; dTxBit = 1; step(); dTxStrobe = 0; dTxBit = 0;
    pktActive = 1; echoStrobe = 1; echoBit = 1; step(); echoStrobe = 0;
    readResp("R9 match no event", 8'h00);
    pktActive = 0; echoStrobe = 1; echoBit = 0; step(); echoStrobe = 0;
    readResp("R9 no packet", 8'h00);
    pktActive = 1; echoStrobe = 1; echoBit = 0; step(); echoStrobe = 0; pktActive = 0;
    readResp("R9 lost collision", 8'h04);
  endtask

  task automatic testSameEdge();
    step();
    cmdValid = 1; evDeact = 1;
    step();
    cmdValid = 0; evDeact = 0;
    chk("R10 response excludes", respCode, 8'h00);
    chk("R10 irq kept", {7'd0, irq}, 8'd1);
    readResp("R10 reported next", 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    testReset();
    testNoClockBeforeEnable();
    testPriority();
    testSlips();
    testStateMode();
    testMasks();
    testMfClock();
    testCollision();
    testSameEdge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule